// File: doc/BRIEF.md
# Cascadable Serial Output Latch Controller

This block drives eight active-high channel enables from a three-wire serial link. The link has a serial clock, an active-low select and a data line. While the select is low, each rising edge of the serial clock shifts one data bit into an 8-bit staging register. When the select returns high, the staging register is copied into the output latch that drives the channels. A serial data output, taken from the last stage of the staging register, lets several units share one link in a chain. Two active-low force inputs switch every channel off or on at once. The force-off input wins whenever both are asserted.

Every serial and force input is passed through a synchroniser into a fast system clock domain, and edges are detected there. The system clock must run at least four times faster than the serial clock. A staging action therefore takes effect a fixed three system clocks after the pin changes: the two synchroniser stages plus the edge-detect register.

Top module: `serial_latch_ctrl`

## Requirements
- R1: After the asynchronous reset `rst_n`, all channels are off, the staging register holds zero and `sdo_o` is low.
- R2: While `sel_n_i` is low, each rising edge of `sck_i` shifts `sdi_i` into bit 0 and moves the other bits up one place. The first bit of an eight-bit word therefore ends in bit 7, which drives `chan_o[7]`, and the last bit ends in bit 0, which drives `chan_o[0]`.
- R3: `chan_o` keeps its value for as long as `sel_n_i` stays low.
- R4: A low-to-high transition of `sel_n_i` copies the staging register into `chan_o`, whether `sck_i` is high or low at that moment.
- R5: While `sel_n_i` is high, toggling `sck_i` and `sdi_i` changes neither the staging register nor `chan_o`.
- R6: `sdo_o` takes the value of staging bit 7 only on a falling edge of `sck_i`, so it repeats the input stream eight serial clocks later.
- R7: When more or fewer than eight bits are shifted in one select window, the staging register holds the most recent eight bits. With fewer bits, the older contents move up by the number of bits shifted.
- R8: While `all_off_n_i` is low, the staging register, `chan_o` and `sdo_o` are all cleared. This holds whatever the state of every other input, including `all_on_n_i`.
- R9: While `all_on_n_i` is low and `all_off_n_i` is high, the staging register and `chan_o` are all ones and `sdo_o` is high, whatever the state of the serial inputs.
- R10: With two units chained through `sdo_o`, and sixteen bits shifted in one select window, the far unit latches the first eight bits and the near unit latches the last eight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sck_i | input | 1 | Serial clock |
| sel_n_i | input | 1 | Active-low select; its rising edge commits the staged word |
| sdi_i | input | 1 | Serial data in |
| all_on_n_i | input | 1 | Active-low force of every channel on |
| all_off_n_i | input | 1 | Active-low force of every channel off; overrides all other inputs |
| chan_o | output | CH | Channel enables, bit i drives channel i+1 |
| sdo_o | output | 1 | Serial data out for chaining |

## Verification
The bench chains two units and shifts sixteen-bit streams through them. A unit that took its bits in the wrong order, or updated `sdo_o` on the rising serial edge, would leave the far unit holding a shifted or bit-reversed byte. Short and long bursts check that only the newest eight bits survive; a design that counted bits or cleared the register at select fall would latch the wrong value. The commit is made with the serial clock held high, and clocks are toggled while the unit is deselected, to catch a latch that is gated by the clock level or a register that keeps shifting. Both force inputs are asserted together and then released, followed by a commit with no clocks. This exposes a force that changed only the outputs and left the staging register untouched, or a force-on that beat force-off.

// File: rtl/serial_latch_ctrl.sv
module serial_latch_ctrl #(
  parameter int CH          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_i,
  input  logic          sel_n_i,
  input  logic          sdi_i,
  input  logic          all_on_n_i,
  input  logic          all_off_n_i,
  output logic [CH-1:0] chan_o,
  output logic          sdo_o
);

  localparam int NIN = 5;
  localparam logic [NIN-1:0] IDLE = 5'b11010;

  logic [NIN-1:0] raw;
  logic [NIN-1:0] stg [SYNC_STAGES];
  logic [NIN-1:0] dly;
  logic [CH-1:0]  shreg;

  assign raw = {all_off_n_i, all_on_n_i, sdi_i, sel_n_i, sck_i};

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)  stg[g] <= IDLE;
        else if (g == 0) stg[g] <= raw;
        else         stg[g] <= stg[(g == 0) ? 0 : g-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dly <= IDLE;
    else        dly <= stg[SYNC_STAGES-1];

  logic [NIN-1:0] cur;
  assign cur = stg[SYNC_STAGES-1];

  logic sck_rise, sck_fall, sel_rise, sel_lvl, sel_prev, bit_in, on_req, off_req;
  assign sck_rise = cur[0] & ~dly[0];
  assign sck_fall = ~cur[0] & dly[0];
  assign sel_lvl  = cur[1];
  assign sel_prev = dly[1];
  assign sel_rise = sel_lvl & ~sel_prev;
  assign bit_in   = cur[2];
  assign on_req   = ~cur[3];
  assign off_req  = ~cur[4];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg  <= '0;
      chan_o <= '0;
      sdo_o  <= 1'b0;
    end else if (off_req) begin
      shreg  <= '0;
      chan_o <= '0;
      sdo_o  <= 1'b0;
    end else if (on_req) begin
      shreg  <= '1;
      chan_o <= '1;
      sdo_o  <= 1'b1;
    end else begin
      if (!sel_lvl && sck_rise) shreg  <= {shreg[CH-2:0], bit_in};
      if (sel_rise)             chan_o <= shreg;
      if (sck_fall)             sdo_o  <= shreg[CH-1];
    end

endmodule

// File: rtl/serial_latch_ctrl_chk.sv
module serial_latch_ctrl_chk #(
  parameter int CH = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_lvl,
  input logic          sel_prev,
  input logic          sel_rise,
  input logic          sck_fall,
  input logic          on_req,
  input logic          off_req,
  input logic [CH-1:0] shreg,
  input logic [CH-1:0] chan_o,
  input logic          sdo_o
);

  p_hold_while_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_lvl && !on_req && !off_req) |=> $stable(chan_o));

  p_commit_copies_stage_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rise && !on_req && !off_req) |=> (chan_o == $past(shreg)));

  p_idle_keeps_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_lvl && sel_prev && !on_req && !off_req) |=> $stable(shreg));

  p_sdo_only_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !on_req && !off_req) |=> $stable(sdo_o));

  p_force_off_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    off_req |=> (chan_o == '0 && shreg == '0 && !sdo_o));

  p_force_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (on_req && !off_req) |=> (chan_o == '1 && shreg == '1 && sdo_o));

endmodule

bind serial_latch_ctrl serial_latch_ctrl_chk #(.CH(CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_lvl(sel_lvl), .sel_prev(sel_prev),
  .sel_rise(sel_rise), .sck_fall(sck_fall), .on_req(on_req), .off_req(off_req),
  .shreg(shreg), .chan_o(chan_o), .sdo_o(sdo_o)
);

// File: tb/serial_latch_ctrl_tb.sv
module serial_latch_ctrl_tb;
  localparam int HALF = 6;
  localparam int NV = 4;
  localparam logic [15:0] VEC [NV] = '{16'hA53C, 16'h0FF0, 16'h8001, 16'h6E19};

  logic clk = 0, rst_n = 0;
  logic sck = 0, sel_n = 1, sdi = 0, on_n = 1, off_n = 1;
  logic [7:0] chan_a, chan_b;
  logic sdo_a, sdo_b;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_latch_ctrl u_dut (.clk(clk), .rst_n(rst_n), .sck_i(sck), .sel_n_i(sel_n),
    .sdi_i(sdi), .all_on_n_i(on_n), .all_off_n_i(off_n), .chan_o(chan_a), .sdo_o(sdo_a));
  serial_latch_ctrl u_dut_far (.clk(clk), .rst_n(rst_n), .sck_i(sck), .sel_n_i(sel_n),
    .sdi_i(sdo_a), .all_on_n_i(on_n), .all_off_n_i(off_n), .chan_o(chan_b), .sdo_o(sdo_b));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rise(input logic b);
    @(negedge clk); sdi = b;
    wait_clk(HALF); sck = 1;
    wait_clk(HALF);
  endtask

  task automatic fall();
    @(negedge clk); sck = 0;
    wait_clk(HALF);
  endtask

  task automatic send(input logic [15:0] v, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      rise(v[i]);
      fall();
    end
  endtask

  task automatic set_sel(input logic v);
    @(negedge clk); sel_n = v;
    wait_clk(HALF);
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1;
    wait_clk(4);
    check("R1 chan", chan_a, 8'h00);
    check("R1 sdo", {7'd0, sdo_a}, 8'h00);

    for (int k = 0; k < NV; k++) begin
      logic [7:0] prev_a;
      prev_a = chan_a;
      set_sel(0);
      send(VEC[k] >> 12, 4);
      check("R3 hold mid-burst", chan_a, prev_a);
      send(VEC[k], 12);
      check("R3 hold end-burst", chan_a, prev_a);
      set_sel(1);
      check("R10 near unit", chan_a, VEC[k][7:0]);
      check("R10 far unit", chan_b, VEC[k][15:8]);
      check("R6 sdo last stage", {7'd0, sdo_a}, {7'd0, VEC[k][7]});
    end

    // R7 short burst: 0x19 with 3 bits 101 -> 0xCD
    set_sel(0); send(16'h0005, 3); set_sel(1);
    check("R7 short burst", chan_a, 8'hCD);
    // R7 long burst: 11 bits 0x5F3 -> 0xF3
    set_sel(0); send(16'h05F3, 11); set_sel(1);
    check("R7 long burst", chan_a, 8'hF3);

    // R4 commit with sck held high
    set_sel(0); send(16'h003C >> 1, 7); rise(1'b0);
    set_sel(1);
    check("R4 commit sck high", chan_a, 8'h3C);
    fall();

    // R5 activity while deselected is ignored
    for (int i = 0; i < 8; i++) begin rise(1'b1); fall(); end
    check("R5 chan unchanged", chan_a, 8'h3C);
    set_sel(0); set_sel(1);
    check("R5 stage unchanged", chan_a, 8'h3C);

    // R8 both forces together, off wins
    @(negedge clk); on_n = 0; off_n = 0;
    wait_clk(HALF);
    check("R8 off beats on", chan_a, 8'h00);
    check("R8 far off", chan_b, 8'h00);
    check("R8 sdo low", {7'd0, sdo_a}, 8'h00);
    @(negedge clk); off_n = 1;
    wait_clk(HALF);
    check("R9 all on", chan_a, 8'hFF);
    check("R9 sdo high", {7'd0, sdo_a}, 8'h01);
    @(negedge clk); on_n = 1;
    wait_clk(HALF);
    set_sel(0); set_sel(1);
    check("R9 stage ones", chan_a, 8'hFF);
    @(negedge clk); off_n = 0;
    wait_clk(HALF);
    @(negedge clk); off_n = 1;
    wait_clk(HALF);
    set_sel(0); set_sel(1);
    check("R8 stage cleared", chan_a, 8'h00);

    // R6 sdo moves on falling edge only; R2 bit order
    set_sel(0);
    rise(1'b1); fall();
    send(16'h0000, 6);
    rise(1'b0);
    check("R6 no change at rise", {7'd0, sdo_a}, 8'h00);
    fall();
    check("R6 change at fall", {7'd0, sdo_a}, 8'h01);
    set_sel(1);
    check("R2 first bit to channel 8", chan_a, 8'h80);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule